// File: doc/BRIEF.md
# Speculative Load Delay-on-Miss Gate

This block sits between a load pipeline and a first-level data cache lookup. It decides, for every load, whether the load is still speculative and may be cancelled. It then keeps such a load from changing any persistent cache state. Each load carries a sequence tag. A load is treated as safe once it is older than the oldest branch that has not yet resolved. An optional stricter mode also requires it to be older than the oldest memory operation whose address is still unknown.

A speculative load that hits gets its data straight away. The replacement-state update that the hit would cause is parked instead and is released only when the load turns safe. A speculative load that misses sends no fill request. It waits in the same parking buffer and goes to the next level once safe. Safe loads pass straight through. A squash deletes every parked item younger than the squashing branch, so nothing of it ever reaches the cache. Parked items leave oldest first, one per cycle. A safe load arriving in the same cycle keeps priority on the port it needs.

Top module: `spec_load_gate`

## Requirements
- R1: Age test. Tag a is older than tag b when bit TAG_W-1 of (a - b) is 1, so tags may wrap. A load is safe when br_pend is 0 or its tag is older than br_tag. Otherwise it is speculative.
- R2: A speculative hit is answered on the cycle after acceptance: rsp_valid is 1 and rsp_tag/rsp_data are the load's. On that cycle repl_valid is 0 and fill_valid is 0.
- R3: The deferred replacement update of a parked hit comes out on repl_line/repl_way one cycle after the load turns safe. It is not issued while the load is speculative.
- R4: A speculative miss produces no fill while speculative. Its fill (fill_tag, fill_line) is issued one cycle after it turns safe.
- R5: A safe load skips the buffer. A hit gives a response and a replacement update on the next cycle. A miss gives a fill on the next cycle.
- R6: The buffer holds DEPTH (8) parked items. When it is full, ld_ready is 0 for a speculative load and 1 for a safe one.
- R7: A squash removes every parked item whose tag is younger than sq_tag, and those items cause no later output. A load presented in the same cycle with a tag younger than sq_tag is dropped with no response.
- R8: Safe parked items leave one per cycle, oldest tag first, across misses and deferred updates. A safe load arriving in the same cycle wins the port it needs, and the parked item follows a cycle later.
- R9: When mem_order_en is 1 and addr_pend is 1, a load must also be older than addr_tag to be safe. When mem_order_en is 0, addr_pend and addr_tag have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_order_en | input | 1 | Stricter safety mode that also waits on unknown addresses |
| br_pend | input | 1 | At least one branch unresolved |
| br_tag | input | TAG_W | Tag of the oldest unresolved branch |
| addr_pend | input | 1 | At least one older memory op has no address yet |
| addr_tag | input | TAG_W | Tag of the oldest memory op without an address |
| sq_valid | input | 1 | Squash event this cycle |
| sq_tag | input | TAG_W | Tag of the squashing branch |
| ld_valid | input | 1 | Load presented |
| ld_ready | output | 1 | Load can be accepted |
| ld_tag | input | TAG_W | Load sequence tag |
| ld_line | input | LINE_W | Cache line index of the load |
| ld_hit | input | 1 | Lookup result: 1 hit, 0 miss |
| ld_way | input | WAY_W | Hit way |
| ld_data | input | DATA_W | Hit data |
| rsp_valid | output | 1 | Load data response |
| rsp_tag | output | TAG_W | Response tag |
| rsp_data | output | DATA_W | Response data |
| repl_valid | output | 1 | Replacement-state update command |
| repl_line | output | LINE_W | Line to update |
| repl_way | output | WAY_W | Way to mark as recently used |
| fill_valid | output | 1 | Fill request to the next level |
| fill_tag | output | TAG_W | Tag of the missing load |
| fill_line | output | LINE_W | Line to fetch |

## Verification
A vector table sends single loads under different mixes of pending branch, wrapped tags, strict mode, unknown address and squash. This separates the safe, speculative and dropped outcomes of the age test by the three output strobes alone. Directed sequences then park items and release them. They check that updates and fills appear only after the release cycle, that a mixed batch drains in tag order rather than arrival order, and that a safe load on the same cycle pushes a parked fill back by one cycle. A full buffer is filled to show backpressure for speculative loads only. A partial squash is then checked to see that only the older parked miss survives.

// File: rtl/spec_gate_pkg.sv
package spec_gate_pkg;
  typedef enum logic {
    PK_MISS = 1'b0,
    PK_UPD  = 1'b1
  } park_kind_e;
endpackage

// File: rtl/sg_age_safe.sv
module sg_age_safe #(
  parameter int TAG_W = 6
) (
  input  logic [TAG_W-1:0] tag,
  input  logic             br_pend,
  input  logic [TAG_W-1:0] br_tag,
  input  logic             ord_en,
  input  logic             addr_pend,
  input  logic [TAG_W-1:0] addr_tag,
  output logic             safe
);
  logic [TAG_W-1:0] d_br;
  logic [TAG_W-1:0] d_ad;

  assign d_br = tag - br_tag;
  assign d_ad = tag - addr_tag;

  // older-than test: wrapped difference is negative
  assign safe = (!br_pend || d_br[TAG_W-1]) &&
                (!ord_en || !addr_pend || d_ad[TAG_W-1]);
endmodule

// File: rtl/sg_oldest_pick.sv
module sg_oldest_pick #(
  parameter int N     = 8,
  parameter int TAG_W = 6,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]            req,
  input  logic [N-1:0][TAG_W-1:0] tags,
  output logic                    found,
  output logic [IDX_W-1:0]        idx
);
  logic [TAG_W-1:0] best_tag;
  logic [TAG_W-1:0] diff;

  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_tag = '0;
    diff     = '0;
    for (int i = 0; i < N; i++) begin
      diff = tags[i] - best_tag;
      if (req[i] && (!found || diff[TAG_W-1])) begin
        found    = 1'b1;
        idx      = IDX_W'(i);
        best_tag = tags[i];
      end
    end
  end
endmodule

// File: rtl/sg_free_pick.sv
module sg_free_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     busy,
  output logic             any_free,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        idx      = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/spec_load_gate.sv
module spec_load_gate
  import spec_gate_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int LINE_W = 10,
  parameter int WAY_W  = 2,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_order_en,
  input  logic              br_pend,
  input  logic [TAG_W-1:0]  br_tag,
  input  logic              addr_pend,
  input  logic [TAG_W-1:0]  addr_tag,
  input  logic              sq_valid,
  input  logic [TAG_W-1:0]  sq_tag,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [LINE_W-1:0] ld_line,
  input  logic              ld_hit,
  input  logic [WAY_W-1:0]  ld_way,
  input  logic [DATA_W-1:0] ld_data,
  output logic              rsp_valid,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              repl_valid,
  output logic [LINE_W-1:0] repl_line,
  output logic [WAY_W-1:0]  repl_way,
  output logic              fill_valid,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [LINE_W-1:0] fill_line
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok = rst_pipe[1];

  // parking buffer state
  logic [DEPTH-1:0]             vld_q, vld_d;
  park_kind_e                   kind_q [DEPTH];
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [LINE_W-1:0]            line_q [DEPTH];
  logic [WAY_W-1:0]             way_q  [DEPTH];
  logic [DEPTH-1:0]             wr_en;

  // incoming load classification
  logic             in_safe, in_kill, acc, park, dir_fill, dir_repl, full;
  logic [TAG_W-1:0] sq_diff;

  sg_age_safe #(.TAG_W(TAG_W)) u_in_safe (
    .tag(ld_tag), .br_pend(br_pend), .br_tag(br_tag), .ord_en(mem_order_en),
    .addr_pend(addr_pend), .addr_tag(addr_tag), .safe(in_safe)
  );

  assign sq_diff  = sq_tag - ld_tag;
  assign in_kill  = sq_valid && sq_diff[TAG_W-1];
  assign full     = &vld_q;
  assign ld_ready = !(full && !in_safe);
  assign acc      = ld_valid && ld_ready && !in_kill;
  assign park     = acc && !in_safe;
  assign dir_fill = acc && in_safe && !ld_hit;
  assign dir_repl = acc && in_safe && ld_hit;

  // per-entry safety and squash
  logic [DEPTH-1:0] ent_safe, ent_kill, drain_req;
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      logic [TAG_W-1:0] kd;
      sg_age_safe #(.TAG_W(TAG_W)) u_safe (
        .tag(tag_q[g]), .br_pend(br_pend), .br_tag(br_tag), .ord_en(mem_order_en),
        .addr_pend(addr_pend), .addr_tag(addr_tag), .safe(ent_safe[g])
      );
      assign kd           = sq_tag - tag_q[g];
      assign ent_kill[g]  = sq_valid && kd[TAG_W-1];
      assign drain_req[g] = vld_q[g] && ent_safe[g] && !ent_kill[g];
    end
  endgenerate

  logic             pk_found, free_any, drain;
  logic [IDX_W-1:0] pk_idx, free_idx;
  park_kind_e       pk_kind;

  sg_oldest_pick #(.N(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_pick (
    .req(drain_req), .tags(tag_q), .found(pk_found), .idx(pk_idx)
  );

  sg_free_pick #(.N(DEPTH), .IDX_W(IDX_W)) u_free (
    .busy(vld_q), .any_free(free_any), .idx(free_idx)
  );

  assign pk_kind = kind_q[pk_idx];
  // strict oldest-first: head waits if its port is taken by a direct load
  assign drain   = pk_found && ((pk_kind == PK_MISS) ? !dir_fill : !dir_repl);

  // entry next state
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vld_d[i] = vld_q[i] && !ent_kill[i] && !(drain && (pk_idx == IDX_W'(i)));
      wr_en[i] = park && free_any && (free_idx == IDX_W'(i));
      if (wr_en[i]) vld_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) vld_q <= '0;
    else         vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en[i]) begin
        kind_q[i] <= ld_hit ? PK_UPD : PK_MISS;
        tag_q[i]  <= ld_tag;
        line_q[i] <= ld_line;
        way_q[i]  <= ld_way;
      end
    end
  end

  // output next state
  logic              rsp_v_d, fill_v_d, repl_v_d;
  logic [TAG_W-1:0]  fill_tag_d;
  logic [LINE_W-1:0] fill_line_d, repl_line_d;
  logic [WAY_W-1:0]  repl_way_d;

  always_comb begin
    rsp_v_d     = acc && ld_hit;
    fill_v_d    = dir_fill || (drain && pk_kind == PK_MISS);
    repl_v_d    = dir_repl || (drain && pk_kind == PK_UPD);
    fill_tag_d  = dir_fill ? ld_tag  : tag_q[pk_idx];
    fill_line_d = dir_fill ? ld_line : line_q[pk_idx];
    repl_line_d = dir_repl ? ld_line : line_q[pk_idx];
    repl_way_d  = dir_repl ? ld_way  : way_q[pk_idx];
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rsp_valid  <= 1'b0;
      fill_valid <= 1'b0;
      repl_valid <= 1'b0;
      rsp_tag    <= '0;
      rsp_data   <= '0;
      fill_tag   <= '0;
      fill_line  <= '0;
      repl_line  <= '0;
      repl_way   <= '0;
    end else begin
      rsp_valid  <= rsp_v_d;
      fill_valid <= fill_v_d;
      repl_valid <= repl_v_d;
      if (rsp_v_d) begin
        rsp_tag  <= ld_tag;
        rsp_data <= ld_data;
      end
      if (fill_v_d) begin
        fill_tag  <= fill_tag_d;
        fill_line <= fill_line_d;
      end
      if (repl_v_d) begin
        repl_line <= repl_line_d;
        repl_way  <= repl_way_d;
      end
    end
  end
endmodule

// File: rtl/spec_load_gate_chk.sv
module spec_load_gate_chk #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 8
) (
  input logic                    clk,
  input logic                    rst_ok,
  input logic                    mem_order_en,
  input logic                    br_pend,
  input logic [TAG_W-1:0]        br_tag,
  input logic                    addr_pend,
  input logic [TAG_W-1:0]        addr_tag,
  input logic                    sq_valid,
  input logic [TAG_W-1:0]        sq_tag,
  input logic                    ld_valid,
  input logic                    ld_ready,
  input logic [TAG_W-1:0]        ld_tag,
  input logic                    ld_hit,
  input logic                    rsp_valid,
  input logic [TAG_W-1:0]        rsp_tag,
  input logic                    fill_valid,
  input logic [TAG_W-1:0]        fill_tag,
  input logic [DEPTH-1:0]        vld_q,
  input logic [DEPTH-1:0][TAG_W-1:0] tag_q
);
  function automatic logic is_younger(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    logic [TAG_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[TAG_W-1];
  endfunction

  logic ld_live, ld_safe;
  assign ld_live = ld_valid && ld_ready && !(sq_valid && is_younger(ld_tag, sq_tag));
  assign ld_safe = (!br_pend || is_younger(br_tag, ld_tag)) &&
                   (!mem_order_en || !addr_pend || is_younger(addr_tag, ld_tag));

  assert_hit_resp_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (ld_live && ld_hit) |=> (rsp_valid && rsp_tag == $past(ld_tag)));

  assert_fill_safe_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    fill_valid |-> (!$past(br_pend) || is_younger($past(br_tag), fill_tag)));

  assert_bypass_fill_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (ld_live && !ld_hit && ld_safe) |=> (fill_valid && fill_tag == $past(ld_tag)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    !ld_ready |=> ($countones(vld_q) <= $past($countones(vld_q))));

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_sq
      assert_squash_drop_R7: assert property (@(posedge clk) disable iff (!rst_ok)
        sq_valid |=> !(vld_q[g] && is_younger(tag_q[g], $past(sq_tag))));
    end
  endgenerate
endmodule

bind spec_load_gate spec_load_gate_chk #(.TAG_W(TAG_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_ok(rst_ok), .mem_order_en(mem_order_en),
  .br_pend(br_pend), .br_tag(br_tag), .addr_pend(addr_pend), .addr_tag(addr_tag),
  .sq_valid(sq_valid), .sq_tag(sq_tag), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_tag(ld_tag), .ld_hit(ld_hit), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
  .fill_valid(fill_valid), .fill_tag(fill_tag), .vld_q(vld_q), .tag_q(tag_q)
);

// File: tb/spec_load_gate_bench.sv
module spec_load_gate_bench;
  localparam int TAG_W = 6, LINE_W = 10, WAY_W = 2, DATA_W = 32, DEPTH = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, mem_order_en, br_pend, addr_pend, sq_valid;
  logic [TAG_W-1:0]  br_tag, addr_tag, sq_tag, ld_tag;
  logic              ld_valid, ld_ready, ld_hit;
  logic [LINE_W-1:0] ld_line;
  logic [WAY_W-1:0]  ld_way;
  logic [DATA_W-1:0] ld_data;
  logic              rsp_valid, repl_valid, fill_valid;
  logic [TAG_W-1:0]  rsp_tag, fill_tag;
  logic [DATA_W-1:0] rsp_data;
  logic [LINE_W-1:0] repl_line, fill_line;
  logic [WAY_W-1:0]  repl_way;

  spec_load_gate #(.TAG_W(TAG_W), .LINE_W(LINE_W), .WAY_W(WAY_W), .DATA_W(DATA_W), .DEPTH(DEPTH))
  u_spec_load_gate (
    .clk(clk), .rst_n(rst_n), .mem_order_en(mem_order_en),
    .br_pend(br_pend), .br_tag(br_tag), .addr_pend(addr_pend), .addr_tag(addr_tag),
    .sq_valid(sq_valid), .sq_tag(sq_tag), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_tag(ld_tag), .ld_line(ld_line), .ld_hit(ld_hit), .ld_way(ld_way), .ld_data(ld_data),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .repl_valid(repl_valid), .repl_line(repl_line), .repl_way(repl_way),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_line(fill_line)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load(input logic [TAG_W-1:0] t, input logic h, input logic [LINE_W-1:0] l,
                      input logic [WAY_W-1:0] w);
    ld_valid = 1'b1; ld_tag = t; ld_hit = h; ld_line = l; ld_way = w; ld_data = 32'hC0DE_0000 + t;
  endtask

  typedef struct packed {
    logic             bp;
    logic [TAG_W-1:0] bt;
    logic             om;
    logic             ap;
    logic [TAG_W-1:0] at;
    logic             sv;
    logic [TAG_W-1:0] st;
    logic [TAG_W-1:0] tg;
    logic             hit;
    logic             e_rsp;
    logic             e_fill;
    logic             e_repl;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 6'd5,  1'b1, 1'b1, 1'b0, 1'b1}, // R5 safe hit
    '{1'b0, 6'd0,  1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 6'd5,  1'b0, 1'b0, 1'b1, 1'b0}, // R5 safe miss
    '{1'b1, 6'd10, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 6'd5,  1'b1, 1'b1, 1'b0, 1'b1}, // R1 older than branch
    '{1'b1, 6'd10, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 6'd12, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 spec hit
    '{1'b1, 6'd10, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 6'd12, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 spec miss
    '{1'b1, 6'd62, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 6'd1,  1'b0, 1'b0, 1'b0, 1'b0}, // R1 wrapped younger
    '{1'b1, 6'd62, 1'b0, 1'b0, 6'd0, 1'b0, 6'd0, 6'd60, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 wrapped older
    '{1'b0, 6'd0,  1'b1, 1'b1, 6'd0, 1'b0, 6'd0, 6'd1,  1'b1, 1'b1, 1'b0, 1'b0}, // R9 unknown addr older
    '{1'b0, 6'd0,  1'b1, 1'b1, 6'd9, 1'b0, 6'd0, 6'd3,  1'b0, 1'b0, 1'b1, 1'b0}, // R9 unknown addr younger
    '{1'b0, 6'd0,  1'b0, 1'b1, 6'd0, 1'b0, 6'd0, 6'd3,  1'b0, 1'b0, 1'b1, 1'b0}, // R9 mode off
    '{1'b1, 6'd4,  1'b0, 1'b0, 6'd0, 1'b1, 6'd4, 6'd6,  1'b1, 1'b0, 1'b0, 1'b0}, // R7 incoming killed
    '{1'b1, 6'd4,  1'b0, 1'b0, 6'd0, 1'b1, 6'd8, 6'd6,  1'b1, 1'b1, 1'b0, 1'b0}  // R7 incoming survives
  };

  task automatic idle_in();
    ld_valid = 1'b0; ld_tag = '0; ld_hit = 1'b0; ld_line = '0; ld_way = '0; ld_data = '0;
    br_pend = 1'b0; br_tag = '0; addr_pend = 1'b0; addr_tag = '0;
    sq_valid = 1'b0; sq_tag = '0; mem_order_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_in();
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    chk("R5", "reset rsp_valid", rsp_valid, 0);
    chk("R5", "reset fill_valid", fill_valid, 0);
    chk("R3", "reset repl_valid", repl_valid, 0);
    chk("R6", "reset ld_ready", ld_ready, 1);

    // vector table
    for (int i = 0; i < 12; i++) begin
      br_pend = VEC[i].bp; br_tag = VEC[i].bt; mem_order_en = VEC[i].om;
      addr_pend = VEC[i].ap; addr_tag = VEC[i].at; sq_valid = VEC[i].sv; sq_tag = VEC[i].st;
      load(VEC[i].tg, VEC[i].hit, LINE_W'(VEC[i].tg) + 10'd16, 2'd3);
      step();
      chk("R1", $sformatf("vec%0d rsp", i), rsp_valid, VEC[i].e_rsp);
      chk("R1", $sformatf("vec%0d fill", i), fill_valid, VEC[i].e_fill);
      chk("R2", $sformatf("vec%0d repl", i), repl_valid, VEC[i].e_repl);
      if (VEC[i].e_rsp) chk("R2", $sformatf("vec%0d rsp_tag", i), rsp_tag, VEC[i].tg);
      if (VEC[i].e_fill) chk("R5", $sformatf("vec%0d fill_tag", i), fill_tag, VEC[i].tg);
      ld_valid = 1'b0; sq_valid = 1'b1; sq_tag = VEC[i].tg - 6'd1;
      step();
      chk("R7", $sformatf("vec%0d cleanup", i), {rsp_valid, fill_valid, repl_valid}, 0);
      idle_in();
      step();
    end

    // R3: deferred replacement update waits for safety
    br_pend = 1'b1; br_tag = 6'd3;
    load(6'd5, 1'b1, 10'd20, 2'd1);
    step();
    chk("R2", "spec hit rsp", rsp_valid, 1);
    chk("R2", "spec hit rsp_data", rsp_data, 32'hC0DE_0005);
    chk("R3", "no repl while spec", repl_valid, 0);
    ld_valid = 1'b0;
    step();
    chk("R3", "still no repl", repl_valid, 0);
    br_pend = 1'b0;
    step();
    chk("R3", "repl after safe", repl_valid, 1);
    chk("R3", "repl_line", repl_line, 20);
    chk("R3", "repl_way", repl_way, 1);
    step();
    chk("R3", "single repl", repl_valid, 0);

    // R4: parked miss fills only after safety
    br_pend = 1'b1; br_tag = 6'd3;
    load(6'd6, 1'b0, 10'd33, 2'd0);
    step();
    ld_valid = 1'b0;
    chk("R4", "no fill while spec", fill_valid, 0);
    step();
    chk("R4", "no fill later", fill_valid, 0);
    br_pend = 1'b0;
    step();
    chk("R4", "fill after safe", fill_valid, 1);
    chk("R4", "fill_tag", fill_tag, 6);
    chk("R4", "fill_line", fill_line, 33);
    step();

    // R8: oldest first across kinds
    br_pend = 1'b1; br_tag = 6'd3;
    load(6'd7, 1'b0, 10'd1, 2'd0); step();
    load(6'd6, 1'b1, 10'd2, 2'd2); step();
    load(6'd5, 1'b0, 10'd3, 2'd0); step();
    ld_valid = 1'b0; br_pend = 1'b0;
    step();
    chk("R8", "first fill", fill_valid, 1);
    chk("R8", "first fill_tag", fill_tag, 5);
    chk("R8", "no repl first", repl_valid, 0);
    step();
    chk("R8", "second is repl", repl_valid, 1);
    chk("R8", "second repl_line", repl_line, 2);
    chk("R8", "second no fill", fill_valid, 0);
    step();
    chk("R8", "third fill_tag", fill_tag, 7);
    chk("R8", "third fill", fill_valid, 1);
    step();

    // R8: direct safe miss wins the fill port
    br_pend = 1'b1; br_tag = 6'd8;
    load(6'd10, 1'b0, 10'd4, 2'd0); step();
    br_pend = 1'b0;
    load(6'd3, 1'b0, 10'd5, 2'd0); step();
    chk("R8", "direct fill first", fill_tag, 3);
    ld_valid = 1'b0;
    step();
    chk("R8", "parked fill next", fill_tag, 10);
    chk("R8", "parked fill valid", fill_valid, 1);
    step();

    // R6: backpressure when full
    br_pend = 1'b1; br_tag = 6'd3;
    for (int k = 0; k < DEPTH; k++) begin
      load(6'(10 + k), 1'b0, 10'(40 + k), 2'd0);
      #1 chk("R6", $sformatf("ready entry %0d", k), ld_ready, 1);
      step();
    end
    load(6'd20, 1'b0, 10'd60, 2'd0);
    #1 chk("R6", "ready low when full", ld_ready, 0);
    load(6'd1, 1'b0, 10'd61, 2'd0);
    #1 chk("R6", "safe load ready when full", ld_ready, 1);
    step();
    chk("R6", "safe load fills when full", fill_tag, 1);
    ld_valid = 1'b0; sq_valid = 1'b1; sq_tag = 6'd4;
    step();
    sq_valid = 1'b0; br_pend = 1'b0;
    step();
    step();
    chk("R7", "squashed entries never fill", fill_valid, 0);
    br_pend = 1'b1;
    load(6'd20, 1'b0, 10'd60, 2'd0);
    #1 chk("R6", "ready after squash", ld_ready, 1);
    ld_valid = 1'b0; br_pend = 1'b0;
    step();

    // R7: partial squash
    br_pend = 1'b1; br_tag = 6'd2;
    load(6'd4, 1'b0, 10'd6, 2'd0); step();
    load(6'd6, 1'b1, 10'd7, 2'd1); step();
    load(6'd8, 1'b0, 10'd8, 2'd0); step();
    ld_valid = 1'b0; sq_valid = 1'b1; sq_tag = 6'd5;
    step();
    sq_valid = 1'b0; br_pend = 1'b0;
    step();
    chk("R7", "survivor fills", fill_tag, 4);
    step();
    chk("R7", "no fill of squashed", fill_valid, 0);
    chk("R7", "no repl of squashed", repl_valid, 0);
    step();
    chk("R7", "still quiet", fill_valid, 0);

    // R9: strict mode waits on unknown address
    mem_order_en = 1'b1; addr_pend = 1'b1; addr_tag = 6'd4;
    load(6'd6, 1'b0, 10'd9, 2'd0);
    step();
    ld_valid = 1'b0;
    chk("R9", "held on unknown addr", fill_valid, 0);
    addr_pend = 1'b0;
    step();
    chk("R9", "fill after addr known", fill_valid, 1);
    chk("R9", "fill_tag", fill_tag, 6);
    idle_in();
    step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule